// File: doc/BRIEF.md
# Precise Exception Control Unit

This unit is the trap controller for an in-order five-stage pipeline: fetch, decode, execute, memory and writeback. Each cycle it looks at the exception requests raised by the fetch, decode, execute and memory stages, and at an external interrupt line. When any of them is taken, it picks the request from the oldest instruction. It squashes that instruction and every younger one, so nothing after the fault reaches writeback. It also records where the faulting program must resume and why it stopped, and steers fetch to a handler entry point.

The stages are ordered by age, oldest first: memory, execute, decode, fetch. The interrupt is attached to the instruction that sits in execute. Flush and redirect are combinational, so they come out in the same cycle as the request. The EPC and Cause registers load on the clock edge that ends that cycle.

A controller state machine has two states. RUN is normal execution. HANDLER means a trap has been taken and not yet returned from. The transitions are:
- TAKE: RUN to HANDLER on any accepted request.
- RETAKE: HANDLER to HANDLER on a synchronous exception.
- RETURN: HANDLER to RUN on the return strobe.

In every other case the machine stays in its current state.

Top module: `precise_trap_unit`

## Requirements
- R1: After reset, `epc_o` and `cause_o` are zero, `in_handler_o` is 0, and with all requests low `redirect_o` is 0 and `flush_o` is 0000.
- R2: Among simultaneous requests the winner follows the priority memory > execute > interrupt > decode > fetch. The interrupt is a candidate only in RUN. The cause codes are 3 for memory, 2 for execute (overflow), 5 for interrupt, 1 for decode (undefined opcode) and 4 for fetch.
- R3: `flush_o` bit 0 is fetch, bit 1 is decode, bit 2 is execute and bit 3 is memory. A taken request flushes its own stage and all younger stages, and never an older one. The masks are: memory 1111, execute and interrupt 0111, decode 0011, fetch 0001.
- R4: On the edge after a request is taken, `epc_o` becomes the winning instruction's PC plus 4 and `cause_o` becomes its code. The interrupt uses the execute PC.
- R5: In any cycle in which no request is taken, `epc_o` and `cause_o` keep their values.
- R6: With `vec_mode_i` = 0, a taken request sets `redirect_pc_o` to 0x80000180.
- R7: With `vec_mode_i` = 1, a taken request sets `redirect_pc_o` to 0xC0000000 + (cause-1)*0x20. This gives 0xC0000000 for undefined opcode, 0xC0000020 for overflow, 0xC0000040 for memory, 0xC0000060 for fetch and 0xC0000080 for interrupt.
- R8: `in_handler_o` is 1 from the edge after a take until a return. While it is 1, an interrupt alone causes no redirect and no register change.
- R9: In HANDLER, a synchronous exception is still taken, and it overwrites EPC and Cause.
- R10: In HANDLER, `eret_i` with no exception present asserts `redirect_o` with `redirect_pc_o` equal to `epc_o`, and sets `flush_o` to 0011. On the next edge the state returns to RUN. In RUN, `eret_i` has no effect.
- R11: In HANDLER, if an exception and `eret_i` arrive in the same cycle, the exception is taken and the return is dropped.
- R12: `redirect_o` is 1 exactly in the cycles where `flush_o` is non-zero. Both are asserted in the cycle the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_mode_i | input | 1 | 1 selects cause-vectored handler entry, 0 selects the fixed entry |
| if_exc_i | input | 1 | Fetch-stage fault request |
| if_pc_i | input | 32 | PC of the fetch-stage instruction |
| id_exc_i | input | 1 | Decode-stage undefined-opcode request |
| id_pc_i | input | 32 | PC of the decode-stage instruction |
| ex_exc_i | input | 1 | Execute-stage overflow request |
| ex_pc_i | input | 32 | PC of the execute-stage instruction |
| mem_exc_i | input | 1 | Memory-stage fault request |
| mem_pc_i | input | 32 | PC of the memory-stage instruction |
| irq_i | input | 1 | External interrupt, level |
| eret_i | input | 1 | Return-from-handler strobe |
| flush_o | output | 4 | Per-stage squash: bit 0 fetch, 1 decode, 2 execute, 3 memory |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Redirect target |
| epc_o | output | 32 | Saved resume PC |
| cause_o | output | 4 | Saved cause code |
| in_handler_o | output | 1 | Controller is in the HANDLER state |

## Verification
The assertions assume that the stage flags are raised only by valid instructions and that `eret_i` comes from a single retiring instruction. They take no account of how the pipeline later uses the flush mask. The stimulus raises each flag independently, with low probability, against word-aligned random PCs, and switches the handler mode at random. The flag mix often puts several requests in one cycle, and it puts returns both inside and outside the handler. Directed cycles cover the exact priority collisions, the interrupt mask and the collision of a return with an exception.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic {
        ST_RUN     = 1'b0,
        ST_HANDLER = 1'b1
    } trap_state_e;

    localparam int CAUSE_W = 4;
    localparam int NSTAGE  = 4;
    localparam int NSRC    = 5;

    // Request slots, oldest (highest priority) first
    localparam int SRC_MEM = 0;
    localparam int SRC_EX  = 1;
    localparam int SRC_IRQ = 2;
    localparam int SRC_ID  = 3;
    localparam int SRC_IF  = 4;

    localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = 4'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_OVF   = 4'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_DMEM  = 4'd3;
    localparam logic [CAUSE_W-1:0] CAUSE_IFET  = 4'd4;
    localparam logic [CAUSE_W-1:0] CAUSE_IRQ   = 4'd5;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    logic [N:0] blocked;

    assign blocked[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_slot
            assign grant_o[g]   = req_i[g] & ~blocked[g];
            assign blocked[g+1] = blocked[g] | req_i[g];
        end
    endgenerate

    assign any_o = blocked[N];
endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int          XLEN        = 32,
    parameter int          CW          = 4,
    parameter logic [31:0] FIXED_ENTRY = 32'h8000_0180,
    parameter logic [31:0] VEC_BASE    = 32'hC000_0000,
    parameter int          VEC_SHIFT   = 5
) (
    input  logic            vec_mode_i,
    input  logic [CW-1:0]   cause_i,
    output logic [XLEN-1:0] target_o
);
    logic [XLEN-1:0] slot;

    always_comb begin
        slot = XLEN'(cause_i) - XLEN'(1);
        if (vec_mode_i) begin
            target_o = XLEN'(VEC_BASE) + (slot << VEC_SHIFT);
        end else begin
            target_o = XLEN'(FIXED_ENTRY);
        end
    end
endmodule

// File: rtl/trap_csr.sv
module trap_csr #(
    parameter int XLEN = 32,
    parameter int CW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [XLEN-1:0] epc_d,
    input  logic [CW-1:0]   cause_d,
    output logic [XLEN-1:0] epc_q,
    output logic [CW-1:0]   cause_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (load_i) begin
            epc_q   <= epc_d;
            cause_q <= cause_d;
        end
    end
endmodule

// File: rtl/precise_trap_unit.sv
module precise_trap_unit
    import trap_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          PC_STEP     = 4,
    parameter logic [31:0] FIXED_ENTRY = 32'h8000_0180,
    parameter logic [31:0] VEC_BASE    = 32'hC000_0000,
    parameter int          VEC_SHIFT   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vec_mode_i,
    input  logic               if_exc_i,
    input  logic [XLEN-1:0]    if_pc_i,
    input  logic               id_exc_i,
    input  logic [XLEN-1:0]    id_pc_i,
    input  logic               ex_exc_i,
    input  logic [XLEN-1:0]    ex_pc_i,
    input  logic               mem_exc_i,
    input  logic [XLEN-1:0]    mem_pc_i,
    input  logic               irq_i,
    input  logic               eret_i,
    output logic [NSTAGE-1:0]  flush_o,
    output logic               redirect_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic [XLEN-1:0]    epc_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               in_handler_o
);
    localparam logic [NSTAGE-1:0] RET_FLUSH = 4'b0011;

    trap_state_e state_q, state_d;

    logic [NSRC-1:0]    req, grant;
    logic               take, ret;
    logic [XLEN-1:0]    src_pc    [NSRC];
    logic [CAUSE_W-1:0] src_cause [NSRC];
    logic [NSTAGE-1:0]  src_flush [NSRC];
    logic [XLEN-1:0]    sel_pc;
    logic [CAUSE_W-1:0] sel_cause;
    logic [NSTAGE-1:0]  sel_flush;
    logic [XLEN-1:0]    handler_pc;

    // Request table, oldest slot first
    assign req[SRC_MEM] = mem_exc_i;
    assign req[SRC_EX]  = ex_exc_i;
    assign req[SRC_IRQ] = irq_i & (state_q == ST_RUN);
    assign req[SRC_ID]  = id_exc_i;
    assign req[SRC_IF]  = if_exc_i;

    assign src_pc[SRC_MEM] = mem_pc_i;
    assign src_pc[SRC_EX]  = ex_pc_i;
    assign src_pc[SRC_IRQ] = ex_pc_i;
    assign src_pc[SRC_ID]  = id_pc_i;
    assign src_pc[SRC_IF]  = if_pc_i;

    assign src_cause[SRC_MEM] = CAUSE_DMEM;
    assign src_cause[SRC_EX]  = CAUSE_OVF;
    assign src_cause[SRC_IRQ] = CAUSE_IRQ;
    assign src_cause[SRC_ID]  = CAUSE_UNDEF;
    assign src_cause[SRC_IF]  = CAUSE_IFET;

    assign src_flush[SRC_MEM] = 4'b1111;
    assign src_flush[SRC_EX]  = 4'b0111;
    assign src_flush[SRC_IRQ] = 4'b0111;
    assign src_flush[SRC_ID]  = 4'b0011;
    assign src_flush[SRC_IF]  = 4'b0001;

    trap_arbiter #(.N(NSRC)) u_arb (
        .req_i   (req),
        .grant_o (grant),
        .any_o   (take)
    );

    // One-hot select of the winning slot
    always_comb begin
        sel_pc    = '0;
        sel_cause = '0;
        sel_flush = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                sel_pc    = sel_pc | src_pc[i];
                sel_cause = sel_cause | src_cause[i];
                sel_flush = sel_flush | src_flush[i];
            end
        end
    end

    trap_vector #(
        .XLEN        (XLEN),
        .CW          (CAUSE_W),
        .FIXED_ENTRY (FIXED_ENTRY),
        .VEC_BASE    (VEC_BASE),
        .VEC_SHIFT   (VEC_SHIFT)
    ) u_vec (
        .vec_mode_i (vec_mode_i),
        .cause_i    (sel_cause),
        .target_o   (handler_pc)
    );

    trap_csr #(.XLEN(XLEN), .CW(CAUSE_W)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (take),
        .epc_d   (sel_pc + XLEN'(PC_STEP)),
        .cause_d (sel_cause),
        .epc_q   (epc_o),
        .cause_q (cause_o)
    );

    assign ret = (state_q == ST_HANDLER) & eret_i & ~take;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d       = state_q;
        flush_o       = '0;
        redirect_o    = 1'b0;
        redirect_pc_o = '0;
        unique case (state_q)
            ST_RUN: begin
                if (take) begin              // TAKE
                    state_d       = ST_HANDLER;
                    flush_o       = sel_flush;
                    redirect_o    = 1'b1;
                    redirect_pc_o = handler_pc;
                end
            end
            ST_HANDLER: begin
                if (take) begin              // RETAKE
                    state_d       = ST_HANDLER;
                    flush_o       = sel_flush;
                    redirect_o    = 1'b1;
                    redirect_pc_o = handler_pc;
                end else if (ret) begin      // RETURN
                    state_d       = ST_RUN;
                    flush_o       = RET_FLUSH;
                    redirect_o    = 1'b1;
                    redirect_pc_o = epc_o;
                end
            end
        endcase
    end

    assign in_handler_o = (state_q == ST_HANDLER);

endmodule

// File: rtl/precise_trap_unit_chk.sv
module precise_trap_unit_chk #(
    parameter int          XLEN        = 32,
    parameter logic [31:0] FIXED_ENTRY = 32'h8000_0180
) (
    input logic            clk,
    input logic            rst_n,
    input logic            vec_mode_i,
    input logic            if_exc_i,
    input logic            id_exc_i,
    input logic            ex_exc_i,
    input logic            mem_exc_i,
    input logic [XLEN-1:0] mem_pc_i,
    input logic            irq_i,
    input logic            eret_i,
    input logic [3:0]      flush_o,
    input logic            redirect_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic [XLEN-1:0] epc_o,
    input logic [3:0]      cause_o,
    input logic            in_handler_o
);
    logic any_sync;
    assign any_sync = if_exc_i | id_exc_i | ex_exc_i | mem_exc_i;

    p_flush_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_o[3] || flush_o[2]) && (!flush_o[2] || flush_o[1]) && (!flush_o[1] || flush_o[0]));

    p_overflow_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_exc_i && !mem_exc_i) |-> (flush_o == 4'b0111));

    p_redirect_flush_r12: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o == (flush_o != 4'b0000));

    p_epc_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_exc_i |=> (epc_o == $past(mem_pc_i) + 32'd4) && (cause_o == 4'd3));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |=> $stable(epc_o) && $stable(cause_o));

    p_fixed_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && !in_handler_o && !vec_mode_i) |-> (redirect_pc_o == FIXED_ENTRY));

    p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && !in_handler_o) |=> in_handler_o);

    p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler_o && irq_i && !any_sync && !eret_i) |-> !redirect_o);

    p_eret_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_handler_o && eret_i && !any_sync && !irq_i) |-> !redirect_o);

    p_eret_lose_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler_o && eret_i && any_sync) |=> in_handler_o);
endmodule

bind precise_trap_unit precise_trap_unit_chk #(
    .XLEN        (XLEN),
    .FIXED_ENTRY (FIXED_ENTRY)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vec_mode_i    (vec_mode_i),
    .if_exc_i      (if_exc_i),
    .id_exc_i      (id_exc_i),
    .ex_exc_i      (ex_exc_i),
    .mem_exc_i     (mem_exc_i),
    .mem_pc_i      (mem_pc_i),
    .irq_i         (irq_i),
    .eret_i        (eret_i),
    .flush_o       (flush_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .epc_o         (epc_o),
    .cause_o       (cause_o),
    .in_handler_o  (in_handler_o)
);

// File: tb/precise_trap_unit_bench.sv
module precise_trap_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_mode_i = 1'b0;
    logic        if_exc_i = 1'b0, id_exc_i = 1'b0, ex_exc_i = 1'b0, mem_exc_i = 1'b0;
    logic [31:0] if_pc_i = '0, id_pc_i = '0, ex_pc_i = '0, mem_pc_i = '0;
    logic        irq_i = 1'b0, eret_i = 1'b0;
    logic [3:0]  flush_o;
    logic        redirect_o;
    logic [31:0] redirect_pc_o, epc_o;
    logic [3:0]  cause_o;
    logic        in_handler_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model state
    bit          m_hand = 1'b0;
    logic [31:0] m_epc = '0;
    logic [3:0]  m_cause = '0;

    always #5 clk = ~clk;

    precise_trap_unit u_precise_trap_unit (
        .clk(clk), .rst_n(rst_n), .vec_mode_i(vec_mode_i),
        .if_exc_i(if_exc_i), .if_pc_i(if_pc_i),
        .id_exc_i(id_exc_i), .id_pc_i(id_pc_i),
        .ex_exc_i(ex_exc_i), .ex_pc_i(ex_pc_i),
        .mem_exc_i(mem_exc_i), .mem_pc_i(mem_pc_i),
        .irq_i(irq_i), .eret_i(eret_i),
        .flush_o(flush_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .epc_o(epc_o), .cause_o(cause_o), .in_handler_o(in_handler_o)
    );

    function automatic logic [31:0] vec_target(input bit vm, input logic [3:0] c);
        if (!vm) return 32'h8000_0180;
        return 32'hC000_0000 + (32'(c) - 32'd1) * 32'h20;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input bit vm, input bit f_if, input bit f_id, input bit f_ex,
                         input bit f_mem, input bit irq, input bit er);
        vec_mode_i = vm; if_exc_i = f_if; id_exc_i = f_id; ex_exc_i = f_ex;
        mem_exc_i = f_mem; irq_i = irq; eret_i = er;
        if_pc_i  = {$urandom()} & 32'hFFFF_FFFC;
        id_pc_i  = {$urandom()} & 32'hFFFF_FFFC;
        ex_pc_i  = {$urandom()} & 32'hFFFF_FFFC;
        mem_pc_i = {$urandom()} & 32'hFFFF_FFFC;
    endtask

    // One cycle: inputs already driven after negedge; check before posedge, then advance model
    task automatic step(input string tag);
        bit          take, ret;
        logic [3:0]  c, mask;
        logic [31:0] pc;
        #2;
        take = 1'b1; c = '0; mask = '0; pc = '0;
        if (mem_exc_i)               begin c = 4'd3; mask = 4'b1111; pc = mem_pc_i; end
        else if (ex_exc_i)           begin c = 4'd2; mask = 4'b0111; pc = ex_pc_i;  end
        else if (irq_i && !m_hand)   begin c = 4'd5; mask = 4'b0111; pc = ex_pc_i;  end
        else if (id_exc_i)           begin c = 4'd1; mask = 4'b0011; pc = id_pc_i;  end
        else if (if_exc_i)           begin c = 4'd4; mask = 4'b0001; pc = if_pc_i;  end
        else take = 1'b0;
        ret = !take && m_hand && eret_i;
        chk({tag, "/R4 epc"}, epc_o, m_epc);
        chk({tag, "/R4 cause"}, 32'(cause_o), 32'(m_cause));
        chk({tag, "/R8 in_handler"}, 32'(in_handler_o), 32'(m_hand));
        chk({tag, "/R12 redirect"}, 32'(redirect_o), 32'(take || ret));
        chk({tag, "/R3 flush"}, 32'(flush_o), take ? 32'(mask) : (ret ? 32'h3 : 32'h0));
        if (take) chk({tag, vec_mode_i ? "/R7 target" : "/R6 target"},
                      redirect_pc_o, vec_target(vec_mode_i, c));
        else if (ret) chk({tag, "/R10 return target"}, redirect_pc_o, m_epc);
        if (take) begin m_epc = pc + 32'd4; m_cause = c; m_hand = 1'b1; end
        else if (ret) m_hand = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 epc", epc_o, 32'h0);
        chk("R1 cause", 32'(cause_o), 32'h0);
        chk("R1 in_handler", 32'(in_handler_o), 32'h0);
        chk("R1 redirect", 32'(redirect_o), 32'h0);
        chk("R1 flush", 32'(flush_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        drive(0, 0, 0, 0, 0, 0, 1); step("R10 eret in RUN ignored");
        drive(0, 0, 0, 1, 0, 0, 0); step("R6 overflow fixed");
        drive(0, 0, 0, 0, 0, 1, 0); step("R8 irq masked");
        drive(0, 0, 0, 0, 0, 0, 0); step("R5 hold");
        drive(0, 0, 1, 0, 0, 0, 1); step("R11 exception beats eret");
        drive(1, 0, 0, 0, 0, 0, 1); step("R10 return");
        drive(1, 1, 1, 1, 1, 1, 0); step("R2 all at once");
        drive(1, 0, 1, 0, 0, 0, 0); step("R9 retake in handler");
        drive(1, 0, 0, 0, 0, 0, 1); step("R10 return");
        drive(1, 1, 1, 0, 0, 1, 0); step("R2 irq over decode");
        drive(1, 0, 0, 0, 0, 0, 1); step("R10 return");
        drive(1, 1, 0, 0, 0, 0, 0); step("R7 fetch vector");
        drive(1, 0, 0, 1, 0, 0, 0); step("R7 overflow vector");
        drive(1, 1, 1, 1, 0, 0, 0); step("R2 execute oldest");

        for (int n = 0; n < 3000; n++) begin
            drive($urandom_range(1, 0) == 1, $urandom_range(7, 0) == 0,
                  $urandom_range(7, 0) == 0, $urandom_range(7, 0) == 0,
                  $urandom_range(9, 0) == 0, $urandom_range(5, 0) == 0,
                  $urandom_range(3, 0) == 0);
            step("R2 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule